// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Programmable Pin Sense

This block collects three interrupt sources (an external pin, a timer overflow event and a comparator event) and keeps a pending flag for each. Each source has its own enable, and a global enable gates them all. At an instruction boundary the arbiter picks the highest-priority request and offers its vector index to the processor. The offer stays up until the processor acknowledges it.

On acknowledge the arbiter clears the global enable and the flag of the source it served. A return-from-interrupt strobe sets the global enable again. After a return, the arbiter lets exactly one more main-program instruction complete before it accepts the next request. The sense mode of the external pin is programmable: low level, falling edge, rising edge, or a reserved code that never requests.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The offered vector is the lowest-numbered pending, enabled source. The external pin is vector 1, timer overflow is vector 2 and comparator is vector 3; vector 0 is never offered.
- R2: `extSense` selects the pin sense: 2'b00 low level, 2'b01 reserved, 2'b10 falling edge, 2'b11 rising edge. In the reserved code the pin never raises a request or a flag. In rising mode a falling transition sets no flag.
- R3: In low-level mode no external flag is latched, and `pendingOut[0]` reads 0 from the edge after the mode is selected. The pin requests only while its sampled value is low, so a low pulse that ends before acceptance is lost.
- R4: In edge modes the pin passes through one sampling register before edge detection. A pulse held for one full clock period sets the external flag, which is visible on `pendingOut[0]` two clock edges after the pin changes.
- R5: A flag whose source enable or whose global enable is clear stays in `pendingOut` (bit 0 external, bit 1 timer, bit 2 comparator) until it is served or cleared by a one written to the same bit of `flagClr`.
- R6: A request is accepted only at a clock edge where `instrDone` is high, the global enable is set and no post-return gap is pending. `irqValid` rises one edge later and is 0 after reset.
- R7: While `irqValid` is high and `ack` is low, `irqValid` and `irqVector` hold their values, even if a higher-priority source becomes pending.
- R8: An edge with `irqValid` and `ack` both high drops `irqValid`, clears the global enable and clears the served source's flag.
- R9: `retiStrobe` sets the global enable at the next edge. The first `instrDone` after it is never an acceptance point; the next one can be.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extPin | input | 1 | External interrupt pin (read even when the pin is driven as an output) |
| extSense | input | 2 | External pin sense mode |
| timerEvt | input | 1 | Timer overflow event, one-cycle pulse |
| cmpEvt | input | 1 | Comparator event, one-cycle pulse |
| srcEnable | input | 3 | Per-source enables (bit 0 external, bit 1 timer, bit 2 comparator) |
| flagClr | input | 3 | Write-one-to-clear strobes for the pending flags |
| gieSet | input | 1 | Software set of the global enable |
| gieClr | input | 1 | Software clear of the global enable |
| instrDone | input | 1 | Instruction boundary strobe |
| retiStrobe | input | 1 | Return-from-interrupt strobe |
| ack | input | 1 | Processor takes the offered vector |
| irqValid | output | 1 | A vector is on offer |
| irqVector | output | 2 | Offered vector index |
| gieOut | output | 1 | Current global enable |
| pendingOut | output | 3 | Latched pending flags |

## Verification
The properties assume the processor never issues `retiStrobe` while an offer is outstanding. They also assume that software writes to the global enable never coincide with an acknowledge. The stimulus honours both: it only returns or writes the enable with `irqValid` low, and it acknowledges in a cycle of its own. The pin is held high through reset, because the sampling registers start high and a low pin at release would look like a falling edge. Every pin pulse is held for at least one full clock period.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Number of interrupt sources; source i is offered as vector i+1.
  localparam int SRC_N = 3;
  localparam int IDX_W = $clog2(SRC_N + 1);

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_RSVD = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_t;

  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_OFFER = 1'b1
  } arbState_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             clrServed;
    logic [IDX_W-1:0] servedVec;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int VEC_W   = IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin,
  input  senseMode_t         senseMode,
  input  logic [NUM_SRC-1:0] evtIn,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] flagClr,
  input  ctrlStrobes_t       strobes,
  output logic [NUM_SRC-1:0] pendFlags,
  output logic               reqAny,
  output logic [VEC_W-1:0]   bestVec
);

  // Pin sampling: one stage before edge detection, one stage of history.
  logic extSync;
  logic extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync <= 1'b1;
      extPrev <= 1'b1;
    end else begin
      extSync <= extPin;
      extPrev <= extSync;
    end
  end

  logic fallSeen;
  logic riseSeen;
  logic edgeMode;
  logic extSet;

  always_comb begin
    fallSeen = extPrev & ~extSync;
    riseSeen = ~extPrev & extSync;
    edgeMode = (senseMode == SENSE_FALL) || (senseMode == SENSE_RISE);
    unique case (senseMode)
      SENSE_FALL: extSet = fallSeen;
      SENSE_RISE: extSet = riseSeen;
      default:    extSet = 1'b0;
    endcase
  end

  // Per-source set and clear vectors.
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] servedMask;
  logic [NUM_SRC-1:0] clrVec;

  always_comb begin
    setVec    = evtIn;
    setVec[0] = evtIn[0] | extSet;
    for (int i = 0; i < NUM_SRC; i++) begin
      servedMask[i] = strobes.clrServed && (strobes.servedVec == VEC_W'(i + 1));
    end
    clrVec = flagClr | servedMask;
  end

  // Pending flags: a new event wins over a clear in the same cycle.
  for (genvar g = 0; g < NUM_SRC; g++) begin : gFlag
    if (g == 0) begin : gExt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           pendFlags[g] <= 1'b0;
        else if (!edgeMode)  pendFlags[g] <= 1'b0;
        else if (setVec[g])  pendFlags[g] <= 1'b1;
        else if (clrVec[g])  pendFlags[g] <= 1'b0;
      end
    end else begin : gEvt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           pendFlags[g] <= 1'b0;
        else if (setVec[g])  pendFlags[g] <= 1'b1;
        else if (clrVec[g])  pendFlags[g] <= 1'b0;
      end
    end
  end

  // Request lines: level mode uses the sampled pin directly.
  logic [NUM_SRC-1:0] reqLine;
  logic [NUM_SRC-1:0] masked;

  always_comb begin
    reqLine = pendFlags;
    if (senseMode == SENSE_LOW) reqLine[0] = ~extSync;
    masked = reqLine & srcEnable;
  end

  // Fixed priority: lowest index wins.
  always_comb begin
    reqAny  = |masked;
    bestVec = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (masked[i]) bestVec = VEC_W'(i + 1);
    end
  end

endmodule

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import irq_prio_pkg::*;
#(
  parameter int VEC_W = IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqAny,
  input  logic [VEC_W-1:0] bestVec,
  input  logic             instrDone,
  input  logic             retiStrobe,
  input  logic             ack,
  input  logic             gieSet,
  input  logic             gieClr,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector,
  output logic             gieOut,
  output ctrlStrobes_t     strobes
);

  arbState_t        state;
  logic [VEC_W-1:0] vecHold;
  logic             gie;
  logic             gapHold;
  logic             accept;
  logic             taken;

  always_comb begin
    accept = (state == ARB_IDLE) && instrDone && gie && reqAny && !gapHold;
    taken  = (state == ARB_OFFER) && ack;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ARB_IDLE;
      vecHold <= '0;
    end else begin
      unique case (state)
        ARB_IDLE: if (accept) begin
          state   <= ARB_OFFER;
          vecHold <= bestVec;
        end
        ARB_OFFER: if (ack) state <= ARB_IDLE;
        default: state <= ARB_IDLE;
      endcase
    end
  end

  // Global enable: entry clears, return or software sets, software clears.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     gie <= 1'b0;
    else if (taken)                gie <= 1'b0;
    else if (retiStrobe || gieSet) gie <= 1'b1;
    else if (gieClr)               gie <= 1'b0;
  end

  // One-instruction gap after a return.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           gapHold <= 1'b0;
    else if (retiStrobe) gapHold <= 1'b1;
    else if (instrDone)  gapHold <= 1'b0;
  end

  always_comb begin
    irqValid          = (state == ARB_OFFER);
    irqVector         = vecHold;
    gieOut            = gie;
    strobes.clrServed = taken;
    strobes.servedVec = vecHold;
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = SRC_N,
  parameter int VEC_W   = IDX_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extPin,
  input  logic [1:0]         extSense,
  input  logic               timerEvt,
  input  logic               cmpEvt,
  input  logic [NUM_SRC-1:0] srcEnable,
  input  logic [NUM_SRC-1:0] flagClr,
  input  logic               gieSet,
  input  logic               gieClr,
  input  logic               instrDone,
  input  logic               retiStrobe,
  input  logic               ack,
  output logic               irqValid,
  output logic [VEC_W-1:0]   irqVector,
  output logic               gieOut,
  output logic [NUM_SRC-1:0] pendingOut
);

  ctrlStrobes_t       strobes;
  logic               reqAny;
  logic [VEC_W-1:0]   bestVec;
  logic [NUM_SRC-1:0] evtIn;
  senseMode_t         senseMode;

  always_comb begin
    evtIn     = '0;
    evtIn[1]  = timerEvt;
    evtIn[2]  = cmpEvt;
    senseMode = senseMode_t'(extSense);
  end

  irq_prio_datapath #(
    .NUM_SRC (NUM_SRC),
    .VEC_W   (VEC_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .extPin    (extPin),
    .senseMode (senseMode),
    .evtIn     (evtIn),
    .srcEnable (srcEnable),
    .flagClr   (flagClr),
    .strobes   (strobes),
    .pendFlags (pendingOut),
    .reqAny    (reqAny),
    .bestVec   (bestVec)
  );

  irq_prio_control #(
    .VEC_W (VEC_W)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .reqAny     (reqAny),
    .bestVec    (bestVec),
    .instrDone  (instrDone),
    .retiStrobe (retiStrobe),
    .ack        (ack),
    .gieSet     (gieSet),
    .gieClr     (gieClr),
    .irqValid   (irqValid),
    .irqVector  (irqVector),
    .gieOut     (gieOut),
    .strobes    (strobes)
  );

endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker (
  input logic       clk,
  input logic       rstN,
  input logic       senseEdge,
  input logic       timClr,
  input logic       cmpClr,
  input logic       instrDone,
  input logic       retiStrobe,
  input logic       ack,
  input logic       irqValid,
  input logic [1:0] irqVector,
  input logic       gieOut,
  input logic [2:0] pendingOut
);

  // R1
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVector != 2'd0));

  // R3
  level_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !senseEdge |=> !pendingOut[0]);

  // R5
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut[1] && !timClr && !(irqValid && ack && irqVector == 2'd2))
      |=> pendingOut[1]);

  // R5
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendingOut[2] && !cmpClr && !(irqValid && ack && irqVector == 2'd3))
      |=> pendingOut[2]);

  // R6
  accept_point_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqValid) |-> ($past(instrDone) && $past(gieOut)));

  // R7
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !ack) |=> (irqValid && $stable(irqVector)));

  // R8
  take_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && ack) |=> (!irqValid && !gieOut));

  // R9
  reti_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retiStrobe && !irqValid) |=> gieOut);

  // R9
  reti_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid && instrDone && $past(retiStrobe)) |=> !irqValid);

endmodule

bind irq_prio_ctrl irq_prio_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .senseEdge  (extSense[1]),
  .timClr     (flagClr[1]),
  .cmpClr     (flagClr[2]),
  .instrDone  (instrDone),
  .retiStrobe (retiStrobe),
  .ack        (ack),
  .irqValid   (irqValid),
  .irqVector  (irqVector),
  .gieOut     (gieOut),
  .pendingOut (pendingOut)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       extPin;
  logic [1:0] extSense;
  logic       timerEvt, cmpEvt;
  logic [2:0] srcEnable, flagClr;
  logic       gieSet, gieClr, instrDone, retiStrobe, ack;
  logic       irqValid;
  logic [1:0] irqVector;
  logic       gieOut;
  logic [2:0] pendingOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int expQ[$];
  logic prevValid = 1'b0;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .extSense(extSense),
    .timerEvt(timerEvt), .cmpEvt(cmpEvt), .srcEnable(srcEnable),
    .flagClr(flagClr), .gieSet(gieSet), .gieClr(gieClr),
    .instrDone(instrDone), .retiStrobe(retiStrobe), .ack(ack),
    .irqValid(irqValid), .irqVector(irqVector), .gieOut(gieOut),
    .pendingOut(pendingOut)
  );

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: every new offer is compared with the next expected vector.
  always @(negedge clk) begin
    if (rstN && irqValid && !prevValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R1: actual=%0d expected=none (unexpected offer)", irqVector);
      end else begin
        int e;
        e = expQ.pop_front();
        if (int'(irqVector) != e) begin
          errors++;
          $display("FAIL R1: actual=%0d expected=%0d", irqVector, e);
        end
      end
    end
    prevValid = irqValid;
  end

  task automatic pulseGie();
    gieSet = 1'b1; step(); gieSet = 1'b0;
  endtask

  task automatic pulseDone();
    instrDone = 1'b1; step(); instrDone = 1'b0;
  endtask

  // Driver: expect a vector, reach a boundary, take it.
  task automatic serve(input int exp, input string req);
    expQ.push_back(exp);
    pulseDone();
    chk(req, irqValid, 1);
    chk(req, irqVector, exp);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R8", irqValid, 0);
    chk("R8", gieOut, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; extPin = 1'b1; extSense = 2'b10;
    timerEvt = 0; cmpEvt = 0; srcEnable = 3'b000; flagClr = 3'b000;
    gieSet = 0; gieClr = 0; instrDone = 0; retiStrobe = 0; ack = 0;
    step(3);
    rstN = 1'b1;
    step();
    chk("R6", irqValid, 0);
    chk("R8", gieOut, 0);
    chk("R5", pendingOut, 0);

    // R1 priority between timer and comparator; R8 served flag clears.
    srcEnable = 3'b111;
    pulseGie();
    timerEvt = 1; cmpEvt = 1; step(); timerEvt = 0; cmpEvt = 0;
    chk("R5", pendingOut, 3'b110);
    serve(2, "R1");
    chk("R8", pendingOut, 3'b100);
    pulseGie();
    serve(3, "R1");
    chk("R8", pendingOut, 3'b000);

    // R9: return sets enable, first boundary after it is skipped.
    timerEvt = 1; step(); timerEvt = 0;
    retiStrobe = 1; step(); retiStrobe = 0;
    chk("R9", gieOut, 1);
    pulseDone();
    step();
    chk("R9", irqValid, 0);
    serve(2, "R9");

    // R7: offer holds while a higher-priority source arrives.
    pulseGie();
    cmpEvt = 1; step(); cmpEvt = 0;
    expQ.push_back(3);
    pulseDone();
    timerEvt = 1; step(); timerEvt = 0;
    step(4);
    chk("R7", irqValid, 1);
    chk("R7", irqVector, 3);
    ack = 1; step(); ack = 0;
    chk("R7", pendingOut, 3'b010);
    pulseGie();
    serve(2, "R1");

    // R5: masked flag stays pending, then write-one clear.
    pulseGie();
    srcEnable = 3'b101;
    timerEvt = 1; step(); timerEvt = 0;
    pulseDone();
    step();
    chk("R5", irqValid, 0);
    chk("R5", pendingOut, 3'b010);
    flagClr = 3'b010; step(); flagClr = 3'b000;
    chk("R5", pendingOut, 3'b000);
    srcEnable = 3'b111;

    // R4: one-cycle low pulse in falling mode.
    extSense = 2'b10;
    extPin = 0; step(); extPin = 1; step();
    chk("R4", pendingOut[0], 1);
    serve(1, "R4");

    // R2: rising mode ignores the fall, catches the rise.
    extSense = 2'b11;
    pulseGie();
    extPin = 0; step(3);
    chk("R2", pendingOut[0], 0);
    extPin = 1; step(2);
    chk("R2", pendingOut[0], 1);
    serve(1, "R2");

    // R2: reserved code never requests.
    extSense = 2'b01;
    pulseGie();
    extPin = 0; step(2); extPin = 1; step(2);
    chk("R2", pendingOut[0], 0);
    pulseDone();
    step();
    chk("R2", irqValid, 0);

    // R3: level mode requests while low, latches nothing.
    extSense = 2'b00;
    extPin = 0; step();
    serve(1, "R3");
    extPin = 1; step(2);
    extPin = 0; step(2); extPin = 1; step(2);
    chk("R3", pendingOut[0], 0);
    pulseGie();
    pulseDone();
    step();
    chk("R3", irqValid, 0);

    // R6: no boundary, no acceptance.
    extSense = 2'b10;
    timerEvt = 1; step(); timerEvt = 0;
    step(5);
    chk("R6", irqValid, 0);
    serve(2, "R6");

    step(2);
    chk("R1", expQ.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule